// File: doc/BRIEF.md
# Protected Scratchpad Write Controller

This block stages writes into a paged nonvolatile array through a 32-byte volatile scratchpad. The array model has sixteen 32-byte data pages plus one 32-byte register page. A host first loads bytes into the scratchpad at a target address, reads the scratchpad back together with the target address and a status byte, and then asks for a copy into the array. To authorize the copy, the host echoes the address and status back to the block.

The first seventeen bytes of the register page control protection. Bytes 0 to 15 each hold a protection code for the data page with the same number, and byte 16 is a lock. Every byte is filtered on its way into the scratchpad. A byte bound for a write-protected page is replaced by the array byte. A byte bound for a write-to-0 page is ANDed with the array byte. The lock, when engaged, refuses copies to write-protected pages and to the register page. While the copy programs the array, a busy output is raised for a short fixed interval.

The host side is byte-serial. A one-cycle `op_start` with an opcode opens a command. Input bytes follow on `in_valid`, and a one-cycle `in_end` closes the command. Response bytes come out one per cycle on `out_valid`.

Top module: `scp_ctrl`

## Requirements
- R1: After reset, `busy` and `out_valid` are 0. A read command then returns target address 0000h and status byte 20h.
- R2: The opcodes are write = 1, read = 2 and copy = 3.
  - A write command carries the address low byte, then the address high byte, then data bytes.
  - Data bytes fill the scratchpad upward from the offset given by address bits 4:0.
  - Bytes that arrive after offset 1Fh has been filled are dropped.
  - The ending offset is the offset of the last byte stored.
- R3: A read command emits the following bytes, one per cycle: address low byte, address high byte, status byte, then the scratchpad bytes from the start offset up to the ending offset. In the status byte, bits 4:0 hold the ending offset, bit 5 is the partial flag, bit 6 is always 0 and bit 7 is the copy-done flag.
- R4: The partial flag is 1 after reset. The partial flag is set by a write that ends with `in_partial` = 1 or that stored no data byte. A write that stores at least one byte and ends with `in_partial` = 0 clears it.
- R5: Every accepted write command clears the copy-done flag. A copy that completes sets it.
- R6: When the protection byte of a data page is 55h, each byte stored for that page is the array byte, whatever the host sent.
- R7: When the protection byte of a data page is AAh, each byte stored for that page is the AND of the host byte and the array byte.
- R8: Register-page bytes 0 to 16 that already hold 55h or AAh are loaded from the array, so they cannot be changed. Any other value stays writable and does not protect its page.
- R9: A lock byte of 55h or AAh blocks copies to 55h-protected pages and to the register page.
  - A blocked copy returns the single byte FFh and leaves the array unchanged.
  - Pages in AAh mode and unprotected pages can still be copied.
- R10: A copy command is ignored if any of the following holds: the three echo bytes are not exactly the address low byte, address high byte and status byte; or the echo byte count is not three; or the partial flag is 1. An ignored copy produces no output and does not raise `busy`.
- R11: An accepted copy programs the bytes from the start offset to the ending offset of the target page.
  - `busy` is high for (bytes copied + PROG_WAIT) cycles.
  - The block then emits the single success byte AAh.
  - Commands started while `busy` is high are ignored.
- R12: A copy whose target lies outside the array is blocked and returns FFh. The target is outside the array when address bits 15:10 are not all 0 or the page field (bits 9:5) is above 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle pulse that opens a command while idle |
| op_code | input | 2 | Command selector: 1 write, 2 read, 3 copy |
| in_valid | input | 1 | A command byte is present on `in_byte` |
| in_byte | input | 8 | Command byte (address, data or echo) |
| in_end | input | 1 | One-cycle pulse that closes a write or copy command |
| in_partial | input | 1 | With `in_end` of a write: trailing bits did not form a byte |
| out_valid | output | 1 | A response byte is present on `out_byte` |
| out_byte | output | 8 | Response byte |
| busy | output | 1 | Array programming interval in progress |

## Verification
The hardest case to reach from the ports is proving that a copy really reached the array, or that a blocked copy left the array alone, because the block never reads the array out directly. The bench gets there in three steps. It programs a page, then writes the page's protection byte through the register page. It then loads the scratchpad again with fresh host data. The filtered load exposes the array content, either as the original bytes or as an AND with the host data. The lock cases are staged the same way: the lock byte is committed first, then copies are attempted to pages in each mode, and later loads show whether anything changed.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int N_PAGES    = 16;
    localparam int PAGE_BYTES = 32;
    localparam int OFF_W      = $clog2(PAGE_BYTES);
    localparam int ARR_BYTES  = (N_PAGES + 1) * PAGE_BYTES;
    localparam int AW         = $clog2(ARR_BYTES);
    localparam int PG_W       = AW - OFF_W;
    localparam int TA_W       = 16;
    localparam int REG_BASE   = N_PAGES * PAGE_BYTES;
    localparam int LOCK_IDX   = REG_BASE + N_PAGES;

    localparam logic [7:0] CODE_WP  = 8'h55;
    localparam logic [7:0] CODE_W0  = 8'hAA;
    localparam logic [7:0] RESP_OK  = 8'hAA;
    localparam logic [7:0] RESP_BLK = 8'hFF;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_COPY  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_WR, S_RD, S_CP, S_PROG, S_WAIT
    } st_e;

    typedef struct packed {
        logic             aa;
        logic             zero;
        logic             pf;
        logic [OFF_W-1:0] end_off;
    } es_t;

    function automatic logic is_lock_code(input logic [7:0] b);
        return (b == CODE_WP) || (b == CODE_W0);
    endfunction

endpackage

// File: rtl/scp_array.sv
module scp_array
    import scp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   rd_addr,
    output logic [7:0]      rd_data,
    input  logic [PG_W-1:0] prot_page,
    output logic [7:0]      prot_data,
    output logic [7:0]      lock_data,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [7:0]      wr_data
);

    logic [7:0] mem [ARR_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARR_BYTES; i++) mem[i] <= 8'hFF;
        end else if (wr_en && (int'(wr_addr) < ARR_BYTES)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_data = RESP_BLK;
        if (int'(rd_addr) < ARR_BYTES) rd_data = mem[rd_addr];
        prot_data = 8'hFF;
        if (int'(prot_page) < N_PAGES)
            prot_data = mem[AW'(REG_BASE) + AW'(prot_page)];
        lock_data = mem[LOCK_IDX];
    end

endmodule

// File: rtl/scp_filter.sv
module scp_filter
    import scp_pkg::*;
(
    input  logic             page_ok,
    input  logic [PG_W-1:0]  page,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       host_byte,
    input  logic [7:0]       arr_byte,
    input  logic [7:0]       prot_byte,
    output logic [7:0]       load_byte
);

    localparam logic [OFF_W-1:0] LAST_CTRL = OFF_W'(N_PAGES);

    always_comb begin
        load_byte = host_byte;
        if (page_ok) begin
            if (int'(page) < N_PAGES) begin
                if (prot_byte == CODE_WP)      load_byte = arr_byte;
                else if (prot_byte == CODE_W0) load_byte = host_byte & arr_byte;
            end else if (off <= LAST_CTRL && is_lock_code(arr_byte)) begin
                load_byte = arr_byte;
            end
        end
    end

endmodule

// File: rtl/scp_ctrl.sv
module scp_ctrl
    import scp_pkg::*;
#(
    parameter int PROG_WAIT = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       op_start,
    input  logic [1:0] op_code,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_end,
    input  logic       in_partial,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       busy
);

    localparam int WC_W = $clog2(PROG_WAIT + 1);
    localparam logic [PG_W-1:0] REG_PAGE = PG_W'(N_PAGES);

    st_e              state;
    logic [TA_W-1:0]  ta;
    es_t              es;
    logic [7:0]       sp [PAGE_BYTES];
    logic [2:0]       cnt;
    logic [OFF_W:0]   ptr;
    logic [OFF_W-1:0] last;
    logic             loaded;
    logic             match;
    logic [OFF_W:0]   rd_idx;
    logic [OFF_W-1:0] prog_ptr;
    logic [WC_W-1:0]  wait_cnt;

    logic [PG_W-1:0]  page;
    logic             page_ok;
    logic [7:0]       arr_rd, prot_rd, lock_rd, load_byte, echo_ref;
    logic [OFF_W-1:0] rd_off;
    logic             blocked;

    assign page    = ta[AW-1:OFF_W];
    assign page_ok = (ta[TA_W-1:AW] == '0) && (page <= REG_PAGE);
    assign busy    = (state == S_PROG) || (state == S_WAIT);
    assign rd_off  = ta[OFF_W-1:0] + rd_idx[OFF_W-1:0] - OFF_W'(3);
    assign blocked = !page_ok ||
                     (is_lock_code(lock_rd) && (page == REG_PAGE || prot_rd == CODE_WP));

    always_comb begin
        case (cnt)
            3'd0:    echo_ref = ta[7:0];
            3'd1:    echo_ref = ta[15:8];
            default: echo_ref = es;
        endcase
    end

    scp_array u_array (
        .clk       (clk),
        .rst       (rst),
        .rd_addr   ({page, ptr[OFF_W-1:0]}),
        .rd_data   (arr_rd),
        .prot_page (page),
        .prot_data (prot_rd),
        .lock_data (lock_rd),
        .wr_en     (state == S_PROG),
        .wr_addr   ({page, prog_ptr}),
        .wr_data   (sp[prog_ptr])
    );

    scp_filter u_filter (
        .page_ok   (page_ok),
        .page      (page),
        .off       (ptr[OFF_W-1:0]),
        .host_byte (in_byte),
        .arr_byte  (arr_rd),
        .prot_byte (prot_rd),
        .load_byte (load_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            ta       <= '0;
            es       <= '{aa: 1'b0, zero: 1'b0, pf: 1'b1, end_off: '0};
            for (int i = 0; i < PAGE_BYTES; i++) sp[i] <= 8'h00;
            cnt      <= '0;
            ptr      <= '0;
            last     <= '0;
            loaded   <= 1'b0;
            match    <= 1'b0;
            rd_idx   <= '0;
            prog_ptr <= '0;
            wait_cnt <= '0;
            out_valid <= 1'b0;
            out_byte  <= 8'h00;
        end else begin
            out_valid <= 1'b0;
            case (state)
                S_IDLE: if (op_start) begin
                    case (op_e'(op_code))
                        OP_WRITE: begin
                            state  <= S_WR;
                            cnt    <= '0;
                            loaded <= 1'b0;
                            es.aa  <= 1'b0;
                        end
                        OP_READ: begin
                            state  <= S_RD;
                            rd_idx <= '0;
                        end
                        OP_COPY: begin
                            state <= S_CP;
                            cnt   <= '0;
                            match <= 1'b1;
                        end
                        default: state <= S_IDLE;
                    endcase
                end
                S_WR: begin
                    if (in_end) begin
                        es.end_off <= loaded ? last : ta[OFF_W-1:0];
                        es.pf      <= in_partial | !loaded;
                        state      <= S_IDLE;
                    end else if (in_valid) begin
                        if (cnt == 3'd0) begin
                            ta[7:0] <= in_byte;
                            ptr     <= {1'b0, in_byte[OFF_W-1:0]};
                            cnt     <= 3'd1;
                        end else if (cnt == 3'd1) begin
                            ta[15:8] <= in_byte;
                            cnt      <= 3'd2;
                        end else if (!ptr[OFF_W]) begin
                            sp[ptr[OFF_W-1:0]] <= load_byte;
                            last   <= ptr[OFF_W-1:0];
                            loaded <= 1'b1;
                            ptr    <= ptr + 1'b1;
                        end
                    end
                end
                S_RD: begin
                    out_valid <= 1'b1;
                    rd_idx    <= rd_idx + 1'b1;
                    case (rd_idx)
                        '0:        out_byte <= ta[7:0];
                        (OFF_W+1)'(1): out_byte <= ta[15:8];
                        (OFF_W+1)'(2): out_byte <= es;
                        default: begin
                            out_byte <= sp[rd_off];
                            if (rd_off == es.end_off) state <= S_IDLE;
                        end
                    endcase
                end
                S_CP: begin
                    if (in_end) begin
                        state <= S_IDLE;
                        if (cnt == 3'd3 && match && !es.pf) begin
                            if (blocked) begin
                                out_valid <= 1'b1;
                                out_byte  <= RESP_BLK;
                            end else begin
                                state    <= S_PROG;
                                prog_ptr <= ta[OFF_W-1:0];
                            end
                        end
                    end else if (in_valid) begin
                        if (cnt >= 3'd3 || in_byte != echo_ref) match <= 1'b0;
                        if (cnt != 3'd7) cnt <= cnt + 1'b1;
                    end
                end
                S_PROG: begin
                    if (prog_ptr == es.end_off) begin
                        state    <= S_WAIT;
                        wait_cnt <= '0;
                    end else begin
                        prog_ptr <= prog_ptr + 1'b1;
                    end
                end
                S_WAIT: begin
                    if (wait_cnt == WC_W'(PROG_WAIT - 1)) begin
                        state     <= S_IDLE;
                        es.aa     <= 1'b1;
                        out_valid <= 1'b1;
                        out_byte  <= RESP_OK;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11: a command offered during programming is not taken up
    assert_busy_ignores_cmd_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && op_start) |=> (busy || state == S_IDLE));

    // R5: the end of programming leaves the copy-done flag set
    assert_copy_sets_done_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> es.aa);

    // R5: while a write is being taken in, copy-done reads 0
    assert_write_clears_done_R5: assert property (@(posedge clk) disable iff (rst)
        (state == S_WR) |-> !es.aa);

    // R4: a whole-byte write with data clears the partial flag
    assert_clean_write_clears_pf_R4: assert property (@(posedge clk) disable iff (rst)
        (state == S_WR && in_end && !in_partial && loaded) |=> !es.pf);

    // R10: a copy while the partial flag is up stays silent
    assert_pf_copy_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (state == S_CP && in_end && es.pf) |=> (!busy && !out_valid));

    // R9: a locked copy to a write-protected data page never programs
    assert_locked_copy_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        (state == S_CP && in_end && is_lock_code(lock_rd) && page_ok &&
         page != REG_PAGE && prot_rd == CODE_WP) |=> !busy);

endmodule

// File: tb/tb_scp_ctrl.sv
`timescale 1ns/1ps
module tb_scp_ctrl;

    localparam int PW = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_start = 1'b0;
    logic [1:0] op_code = 2'd0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_end = 1'b0;
    logic       in_partial = 1'b0;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       busy;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  m_arr [544];
    logic [7:0]  m_sp  [32];
    logic [15:0] m_ta;
    logic [4:0]  m_end;
    logic        m_pf;
    logic        m_aa;
    logic [7:0]  buf_d [40];
    logic [7:0]  cap   [64];
    int          ncap;

    always #10 clk = ~clk;

    scp_ctrl #(.PROG_WAIT(PW)) dut (
        .clk(clk), .rst(rst), .op_start(op_start), .op_code(op_code),
        .in_valid(in_valid), .in_byte(in_byte), .in_end(in_end),
        .in_partial(in_partial), .out_valid(out_valid), .out_byte(out_byte),
        .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [7:0] es_m();
        return {m_aa, 1'b0, m_pf, m_end};
    endfunction

    function automatic logic lockc(input logic [7:0] b);
        return b == 8'h55 || b == 8'hAA;
    endfunction

    function automatic logic [7:0] model_load(input logic [15:0] ta, input int p,
                                              input logic [7:0] host);
        int pg = int'(ta[9:5]);
        int a  = pg * 32 + p;
        logic [7:0] arr, prot;
        if (ta[15:10] != 0 || pg > 16) return host;
        arr = m_arr[a];
        if (pg < 16) begin
            prot = m_arr[512 + pg];
            if (prot == 8'h55) return arr;
            if (prot == 8'hAA) return host & arr;
            return host;
        end
        if (p <= 16 && lockc(arr)) return arr;
        return host;
    endfunction

    task automatic fill(input int base, input int step);
        for (int i = 0; i < 40; i++) buf_d[i] = 8'(base + i * step);
    endtask

    task automatic wr_cmd(input logic [15:0] ta, input int n, input logic partial);
        int off = int'(ta[4:0]);
        int last = 0;
        logic ld = 1'b0;
        @(negedge clk); op_start = 1'b1; op_code = 2'd1;
        @(negedge clk); op_start = 1'b0; in_valid = 1'b1; in_byte = ta[7:0];
        @(negedge clk); in_byte = ta[15:8];
        for (int i = 0; i < n; i++) begin
            @(negedge clk); in_byte = buf_d[i];
        end
        @(negedge clk); in_valid = 1'b0; in_end = 1'b1; in_partial = partial;
        @(negedge clk); in_end = 1'b0; in_partial = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (off + i < 32) begin
                m_sp[off + i] = model_load(ta, off + i, buf_d[i]);
                last = off + i;
                ld = 1'b1;
            end
        end
        m_ta  = ta;
        m_end = ld ? 5'(last) : ta[4:0];
        m_pf  = partial | !ld;
        m_aa  = 1'b0;
    endtask

    task automatic rd_collect();
        @(negedge clk); op_start = 1'b1; op_code = 2'd2;
        @(negedge clk); op_start = 1'b0;
        ncap = 0;
        for (int c = 0; c < 45; c++) begin
            if (out_valid && ncap < 64) begin
                cap[ncap] = out_byte;
                ncap++;
            end
            @(negedge clk);
        end
    endtask

    task automatic rd_check(input string req);
        int off, exp_n;
        rd_collect();
        off = int'(m_ta[4:0]);
        exp_n = 3 + int'(m_end) - off + 1;
        chk(req, ncap, exp_n);
        chk(req, cap[0], m_ta[7:0]);
        chk(req, cap[1], m_ta[15:8]);
        chk(req, cap[2], es_m());
        for (int k = 3; k < ncap && k < exp_n; k++)
            chk(req, cap[k], m_sp[(off + k - 3) & 31]);
    endtask

    task automatic cp_cmd(input logic [7:0] e0, input logic [7:0] e1,
                          input logic [7:0] e2, input logic inj, input string req);
        logic ok, valid, blk;
        int pg, nout, bcnt, first, exp_busy;
        pg = int'(m_ta[9:5]);
        valid = (e0 == m_ta[7:0]) && (e1 == m_ta[15:8]) && (e2 == es_m()) && !m_pf;
        ok = (m_ta[15:10] == 0) && (pg <= 16);
        blk = !ok || (lockc(m_arr[528]) && (pg == 16 || m_arr[512 + pg] == 8'h55));
        exp_busy = int'(m_end) - int'(m_ta[4:0]) + 1 + PW;
        @(negedge clk); op_start = 1'b1; op_code = 2'd3;
        @(negedge clk); op_start = 1'b0; in_valid = 1'b1; in_byte = e0;
        @(negedge clk); in_byte = e1;
        @(negedge clk); in_byte = e2;
        @(negedge clk); in_valid = 1'b0; in_end = 1'b1;
        @(negedge clk); in_end = 1'b0;
        nout = 0; bcnt = 0; first = 0;
        for (int c = 0; c < 80; c++) begin
            if (out_valid) begin
                if (nout == 0) first = int'(out_byte);
                nout++;
            end
            if (busy) bcnt++;
            if (inj && busy && bcnt == 2) begin
                op_start = 1'b1; op_code = 2'd2;
            end else begin
                op_start = 1'b0;
            end
            @(negedge clk);
        end
        op_start = 1'b0;
        if (!valid) begin
            chk(req, nout, 0);
            chk(req, bcnt, 0);
        end else if (blk) begin
            chk(req, nout, 1);
            chk(req, first, 8'hFF);
            chk(req, bcnt, 0);
        end else begin
            chk(req, nout, 1);
            chk(req, first, 8'hAA);
            chk(req, bcnt, exp_busy);
            for (int p = int'(m_ta[4:0]); p <= int'(m_end); p++)
                m_arr[pg * 32 + p] = m_sp[p];
            m_aa = 1'b1;
        end
    endtask

    task automatic cp_ok(input string req);
        cp_cmd(m_ta[7:0], m_ta[15:8], es_m(), 1'b0, req);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        for (int i = 0; i < 544; i++) m_arr[i] = 8'hFF;
        for (int i = 0; i < 32; i++) m_sp[i] = 8'h00;
        m_ta = 16'h0000; m_end = 5'd0; m_pf = 1'b1; m_aa = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1", int'(busy), 0);
        chk("R1", int'(out_valid), 0);
        rd_check("R1");

        // R2/R3: sweep every start offset in page 2, some runs overflow past 1Fh
        for (int off = 0; off < 32; off++) begin
            fill(off * 7, 3);
            wr_cmd(16'h0040 + 16'(off), (off % 7) + 1, 1'b0);
            rd_check("R2");
        end
        fill(8'h11, 1);
        wr_cmd(16'h005D, 6, 1'b0);
        rd_check("R3");

        // R4: partial endings and empty writes raise the flag
        wr_cmd(16'h0044, 3, 1'b1);
        rd_check("R4");
        chk("R4", int'(cap[2][5]), 1);
        cp_ok("R10");
        wr_cmd(16'h0044, 0, 1'b0);
        rd_check("R4");
        wr_cmd(16'h0044, 2, 1'b0);
        rd_check("R4");
        chk("R4", int'(cap[2][5]), 0);

        // R11/R5: full page copy with a command injected while busy
        fill(8'h30, 5);
        wr_cmd(16'h0060, 32, 1'b0);
        rd_check("R11");
        cp_cmd(m_ta[7:0], m_ta[15:8], es_m(), 1'b1, "R11");
        rd_check("R5");
        chk("R5", int'(cap[2][7]), 1);
        fill(8'h01, 1);
        wr_cmd(16'h0061, 1, 1'b0);
        rd_check("R5");
        chk("R5", int'(cap[2][7]), 0);

        // R10: wrong echo is ignored
        wr_cmd(16'h0062, 2, 1'b0);
        cp_cmd(m_ta[7:0], m_ta[15:8], es_m() ^ 8'h01, 1'b0, "R10");
        cp_cmd(m_ta[7:0] ^ 8'h80, m_ta[15:8], es_m(), 1'b0, "R10");
        rd_check("R10");

        // R6: protect page 3, then new host data must read as the stored page
        buf_d[0] = 8'h55;
        wr_cmd(16'h0203, 1, 1'b0);
        cp_ok("R6");
        fill(8'hC3, 1);
        wr_cmd(16'h0060, 32, 1'b0);
        rd_check("R6");

        // R7: page 4 stored, then switched to write-to-0
        fill(8'hF0, 9);
        wr_cmd(16'h0080, 32, 1'b0);
        cp_ok("R7");
        buf_d[0] = 8'hAA;
        wr_cmd(16'h0204, 1, 1'b0);
        cp_ok("R7");
        fill(8'h5A, 13);
        wr_cmd(16'h0080, 32, 1'b0);
        rd_check("R7");

        // R8: self protection of control bytes; other values stay writable
        buf_d[0] = 8'h00;
        wr_cmd(16'h0203, 1, 1'b0);
        rd_check("R8");
        chk("R8", int'(cap[3]), 8'h55);
        buf_d[0] = 8'h12;
        wr_cmd(16'h0205, 1, 1'b0);
        cp_ok("R8");
        buf_d[0] = 8'h34;
        wr_cmd(16'h0205, 1, 1'b0);
        rd_check("R8");
        chk("R8", int'(cap[3]), 8'h34);
        cp_ok("R8");

        // R9: engage the lock, then try each page kind
        buf_d[0] = 8'h55;
        wr_cmd(16'h0210, 1, 1'b0);
        cp_ok("R9");
        buf_d[0] = 8'h00;
        wr_cmd(16'h0210, 1, 1'b0);
        rd_check("R8");
        fill(8'h77, 2);
        wr_cmd(16'h0064, 8, 1'b0);
        cp_ok("R9");
        buf_d[0] = 8'h55;
        wr_cmd(16'h0206, 1, 1'b0);
        cp_ok("R9");
        fill(8'h0F, 1);
        wr_cmd(16'h00C0, 4, 1'b0);
        rd_check("R9");
        fill(8'hE1, 1);
        wr_cmd(16'h0082, 4, 1'b0);
        cp_ok("R9");
        fill(8'h90, 4);
        wr_cmd(16'h00A0, 6, 1'b0);
        cp_ok("R9");
        fill(8'h22, 1);
        wr_cmd(16'h0060, 32, 1'b0);
        rd_check("R9");
        fill(8'hFF, 0);
        wr_cmd(16'h0082, 4, 1'b0);
        rd_check("R9");

        // R12: targets outside the array
        fill(8'h44, 1);
        wr_cmd(16'h0240, 3, 1'b0);
        cp_ok("R12");
        wr_cmd(16'h1000, 3, 1'b0);
        cp_ok("R12");
        rd_check("R12");

        summary();
    end

endmodule